// File: doc/BRIEF.md
# Four-Stream DMA Burst Scheduler

This block chooses which of four DMA streams may use the shared data mover next. Streams are numbered 0 to 3. Each one has its own control word, written over a 32-bit APB slave port. The streams do not all play the same role:

- Streams 0 and 1 follow their peripheral request lines.
- Stream 2 can switch to an external request pin and answers on an external acknowledge pin.
- Stream 3 can run a memory-to-memory move that is started by a software write and needs no request line.

A fixed-priority arbiter picks among the qualified streams. The chosen stream is granted and keeps the grant until the engine reports that the burst is done.

The burst command toward the data engine is a valid/ready channel. `cmd_valid` rises in the cycle after the grant is taken. While `cmd_ready` is low, `cmd_valid` and `cmd_stream` stay unchanged, so the engine can apply back-pressure for as long as it needs. A command is accepted on a clock edge where both signals are high, and `cmd_valid` is low in the cycle after that edge.

The engine then runs the burst. It raises `burst_done` for one cycle at the end, and raises `burst_last` with it when that burst completes the whole transfer. The FIFO, the address counters and the count counters sit in the engine. Grant, acknowledge and the control pins are plain level signals.

Top module: `dma_stream_sched`

## Requirements
- R1: After reset, `grant` is 0, `cmd_valid` is 0 and `ext_ack` is 0. Every register reads 0.
- R2: When no stream is granted, the qualified stream with the lowest index wins. Stream 0 has the highest priority.
- R3: At most one `grant` bit is high. The grant does not change from arbitration until the cycle that `burst_done` is sampled. A request from a higher-priority stream that arrives during a burst waits for that burst boundary.
- R4: `cmd_valid` and `cmd_stream` (the binary index of the granted stream) hold steady until `cmd_ready` is seen. `burst_done` has no effect until the command has been accepted.
- R5: Stream 2 has an external mode, selected by control bit 1. In that mode it is qualified only by `ext_req`, and `periph_req[2]` has no effect.
- R6: `ext_ack` is high while stream 2 holds the grant in external mode and the top `CS_W` bits of `xfer_addr` equal `EXT_REGION`. It is still high in the cycle where `burst_done` is sampled and low in the cycle after.
- R7: Stream 3 has a memory-to-memory mode, selected by control bit 1. Writing 1 to control bit 2 sets a start flag. That flag qualifies the stream with no request line, and it stays set until the stream's last burst is done. Writing 0 to bit 2 leaves the flag unchanged.
- R8: A `burst_done` together with `burst_last` sets the granted stream's status bit and clears its enable bit (bit 0).
- R9: Status bits are write-1-to-clear. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: The control word for stream n sits at byte offset 4n: enable in bit 0, mode in bit 1, start flag in bit 2. The status word sits at offset 0x10, with stream n in bit n. Any other offset reads 0. `pready` is always 1.
- R11: Streams 0 and 1 do not store the mode bit. It reads back 0 and has no effect, so these streams are still qualified by their request lines.
- R12: A stream whose enable bit is 0 is never granted, whatever its request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | PA_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| periph_req | input | 4 | Peripheral request, one bit per stream |
| ext_req | input | 1 | External request pin for stream 2 |
| ext_ack | output | 1 | External acknowledge pin for stream 2 |
| xfer_addr | input | XA_W | Address of the engine's current access |
| grant | output | 4 | One-hot grant |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Burst command ready from the engine |
| cmd_stream | output | 2 | Stream index of the command |
| burst_done | input | 1 | Engine finished the current burst |
| burst_last | input | 1 | The burst that finished ends the transfer |

## Verification
The bench builds the block with a 6-bit APB address, a 16-bit transfer address, a 2-bit chip-select field and `EXT_REGION` set to 3. With these values, a short address such as 0xC000 decodes to the acknowledge region and 0x4000 decodes outside it. Both the hit and the miss case of the acknowledge are therefore driven on a stream 2 burst. A scoreboard records the expected winner of every arbitration, including a high-priority request that must wait behind a burst already running. It checks each accepted command against that record.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  localparam int NSTR       = 4;
  localparam int SID_W      = $clog2(NSTR);
  localparam int DATA_W     = 32;
  localparam int EXT_STREAM = 2;
  localparam int M2M_STREAM = 3;
  localparam int BIT_EN     = 0;
  localparam int BIT_MODE   = 1;
  localparam int BIT_GO     = 2;
  localparam int STATUS_IDX = NSTR;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_BUSY = 2'd2
  } sched_state_t;

  function automatic logic [NSTR-1:0] pick_lowest(input logic [NSTR-1:0] v);
    logic [NSTR-1:0] r;
    r = '0;
    for (int i = NSTR - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [SID_W-1:0] onehot_to_id(input logic [NSTR-1:0] v);
    logic [SID_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSTR; i++)
      if (v[i]) r = SID_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/dsch_regs.sv
module dsch_regs
  import dsch_pkg::*;
#(
  parameter int PA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [PA_W-1:0]   paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NSTR-1:0]   fin_vec,
  output logic [NSTR-1:0]   en,
  output logic [NSTR-1:0]   mode,
  output logic [NSTR-1:0]   go
);
  localparam int IDX_W = PA_W - 2;

  logic             wr_acc;
  logic [IDX_W-1:0] widx;
  logic [NSTR-1:0]  status;
  logic             unused_bits;

  assign wr_acc      = psel & penable & pwrite;
  assign widx        = paddr[PA_W-1:2];
  assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:NSTR]};

  for (genvar n = 0; n < NSTR; n++) begin : g_ctrl
    localparam bit HAS_MODE = (n == EXT_STREAM) || (n == M2M_STREAM);
    localparam bit HAS_GO   = (n == M2M_STREAM);
    logic sel_n;
    assign sel_n = wr_acc && (widx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[n] <= 1'b0;
      end else if (fin_vec[n]) begin
        en[n] <= 1'b0;
      end else if (sel_n) begin
        en[n] <= pwdata[BIT_EN];
      end
    end

    if (HAS_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mode[n] <= 1'b0;
        else if (sel_n) mode[n] <= pwdata[BIT_MODE];
      end
    end else begin : g_nomode
      assign mode[n] = 1'b0;
    end

    if (HAS_GO) begin : g_go
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        go[n] <= 1'b0;
        else if (fin_vec[n])               go[n] <= 1'b0;
        else if (sel_n && pwdata[BIT_GO])  go[n] <= 1'b1;
      end
    end else begin : g_nogo
      assign go[n] = 1'b0;
    end
  end

  // status: set on completion has priority over a write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      for (int i = 0; i < NSTR; i++) begin
        if (fin_vec[i])
          status[i] <= 1'b1;
        else if (wr_acc && widx == IDX_W'(STATUS_IDX) && pwdata[i])
          status[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NSTR; i++) begin
      if (paddr[PA_W-1:2] == IDX_W'(i)) begin
        prdata[BIT_EN]   = en[i];
        prdata[BIT_MODE] = mode[i];
        prdata[BIT_GO]   = go[i];
      end
    end
    if (paddr[PA_W-1:2] == IDX_W'(STATUS_IDX))
      prdata[NSTR-1:0] = status;
  end

  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_vec != '0) |=> ((status & $past(fin_vec)) == $past(fin_vec)));

  p_enable_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_vec != '0) |=> ((en & $past(fin_vec)) == '0));
endmodule

// File: rtl/dsch_qual.sv
module dsch_qual
  import dsch_pkg::*;
(
  input  logic [NSTR-1:0] en,
  input  logic [NSTR-1:0] mode,
  input  logic [NSTR-1:0] go,
  input  logic [NSTR-1:0] periph_req,
  input  logic            ext_req,
  output logic [NSTR-1:0] qual
);
  for (genvar n = 0; n < NSTR; n++) begin : g_q
    if (n == EXT_STREAM) begin : g_ext
      assign qual[n] = en[n] & (mode[n] ? ext_req : periph_req[n]);
    end else if (n == M2M_STREAM) begin : g_m2m
      assign qual[n] = en[n] & (mode[n] ? go[n] : periph_req[n]);
    end else begin : g_plain
      logic unused_sw;
      assign unused_sw = mode[n] ^ go[n];
      assign qual[n]   = en[n] & periph_req[n];
    end
  end
endmodule

// File: rtl/dsch_arb.sv
module dsch_arb
  import dsch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTR-1:0]  qual,
  output logic [NSTR-1:0]  gnt,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [SID_W-1:0] cmd_stream,
  input  logic             burst_done,
  input  logic             burst_last,
  output logic [NSTR-1:0]  fin_vec,
  output logic             bound
);
  sched_state_t state;

  assign cmd_valid  = (state == ST_CMD);
  assign cmd_stream = onehot_to_id(gnt);
  assign bound      = (state == ST_BUSY) && burst_done;
  assign fin_vec    = (bound && burst_last) ? gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      gnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (qual != '0) begin
          gnt   <= pick_lowest(qual);
          state <= ST_CMD;
        end
        ST_CMD: if (cmd_ready) state <= ST_BUSY;
        ST_BUSY: if (burst_done) begin
          gnt   <= '0;
          state <= ST_IDLE;
        end
        default: begin
          gnt   <= '0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_gnt_hold_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD) |=> $stable(gnt));

  p_gnt_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !burst_done) |=> $stable(gnt));

  p_cmd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_stream)));

  p_cmd_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  p_top_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && qual[0]) |=> gnt[0]);

  p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> ((gnt & ~$past(qual)) == '0));
endmodule

// File: rtl/dsch_ext_hs.sv
module dsch_ext_hs
  import dsch_pkg::*;
#(
  parameter int          XA_W       = 32,
  parameter int          CS_W       = 3,
  parameter logic [CS_W-1:0] EXT_REGION = '0
) (
  input  logic            gnt_ext,
  input  logic            ext_mode,
  input  logic [XA_W-1:0] xfer_addr,
  output logic            ext_ack
);
  logic region_hit;
  logic unused_lo;

  assign region_hit = (xfer_addr[XA_W-1 -: CS_W] == EXT_REGION);
  assign unused_lo  = ^xfer_addr[XA_W-CS_W-1:0];
  assign ext_ack    = gnt_ext & ext_mode & region_hit;
endmodule

// File: rtl/dma_stream_sched.sv
module dma_stream_sched
  import dsch_pkg::*;
#(
  parameter int              PA_W       = 8,
  parameter int              XA_W       = 32,
  parameter int              CS_W       = 3,
  parameter logic [CS_W-1:0] EXT_REGION = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [PA_W-1:0]   paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [3:0]        periph_req,
  input  logic              ext_req,
  output logic              ext_ack,
  input  logic [XA_W-1:0]   xfer_addr,
  output logic [3:0]        grant,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_stream,
  input  logic              burst_done,
  input  logic              burst_last
);
  logic [NSTR-1:0] en, mode, go, qual, fin_vec;
  logic            bound;

  assign pready = 1'b1;

  dsch_regs #(.PA_W(PA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .fin_vec(fin_vec),
    .en(en), .mode(mode), .go(go)
  );

  dsch_qual u_qual (
    .en(en), .mode(mode), .go(go), .periph_req(periph_req),
    .ext_req(ext_req), .qual(qual)
  );

  dsch_arb u_arb (
    .clk(clk), .rst_n(rst_n), .qual(qual), .gnt(grant),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_stream(cmd_stream),
    .burst_done(burst_done), .burst_last(burst_last),
    .fin_vec(fin_vec), .bound(bound)
  );

  dsch_ext_hs #(.XA_W(XA_W), .CS_W(CS_W), .EXT_REGION(EXT_REGION)) u_ext (
    .gnt_ext(grant[EXT_STREAM]), .ext_mode(mode[EXT_STREAM]),
    .xfer_addr(xfer_addr), .ext_ack(ext_ack)
  );

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && grant[EXT_STREAM]) |=> !ext_ack);

  p_ack_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> grant[EXT_STREAM]);
endmodule

// File: tb/dma_stream_sched_test.sv
`timescale 1ns/1ps
module dma_stream_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [3:0]  periph_req = '0;
  logic        ext_req = 0;
  logic        ext_ack;
  logic [15:0] xfer_addr = '0;
  logic [3:0]  grant;
  logic        cmd_valid;
  logic        cmd_ready = 0;
  logic [1:0]  cmd_stream;
  logic        burst_done = 0, burst_last = 0;

  int errors = 0;
  int checks = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  dma_stream_sched #(.PA_W(6), .XA_W(16), .CS_W(2), .EXT_REGION(2'd3)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .periph_req(periph_req), .ext_req(ext_req), .ext_ack(ext_ack),
    .xfer_addr(xfer_addr), .grant(grant), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_stream(cmd_stream),
    .burst_done(burst_done), .burst_last(burst_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic apb_write(input logic [5:0] a, input logic [31:0] d);
    step(); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    step(); penable = 1;
    step(); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [5:0] a, output logic [31:0] d);
    step(); psel = 1; pwrite = 0; paddr = a; penable = 0;
    step(); penable = 1;
    @(negedge clk); d = prdata;
    step(); psel = 0; penable = 0;
  endtask

  // engine model: accept command, run, report done; checks ext_ack shape (R6)
  task automatic run_burst(input logic last, input logic ack_exp);
    @(negedge clk);
    while (!cmd_valid) @(negedge clk);
    check("R6 ack at grant", ext_ack, ack_exp);
    step(); cmd_ready = 1;
    step(); cmd_ready = 0;
    step();
    @(negedge clk);
    check("R6 ack in burst", ext_ack, ack_exp);
    step(); burst_done = 1; burst_last = last;
    @(negedge clk);
    check("R6 ack on done", ext_ack, ack_exp);
    step(); burst_done = 0; burst_last = 0;
    @(negedge clk);
    check("R6 ack after done", ext_ack, 0);
  endtask

  // scoreboard monitor: every accepted command must match the next expected stream (R2)
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected command: actual=%0d expected=none", cmd_stream);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(cmd_stream) != e || grant != (4'b1 << e)) begin
          errors++;
          $display("FAIL R2 command stream: actual=%0d/%b expected=%0d", cmd_stream, grant, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 grant", grant, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 ext_ack", ext_ack, 0);
    check("R10 pready", pready, 1);
    apb_read(6'h10, rd); check("R1 status", rd, 0);
    apb_read(6'h0C, rd); check("R1 ctrl3", rd, 0);

    // R12: requests without enable are ignored
    periph_req = 4'b1111;
    repeat (5) step();
    @(negedge clk);
    check("R12 no grant when disabled", cmd_valid, 0);

    // R3: low-priority stream holds grant against later higher-priority enables
    exp_q.push_back(3);
    apb_write(6'h0C, 32'h1);
    apb_write(6'h04, 32'h1);
    apb_write(6'h00, 32'h1);
    @(negedge clk);
    check("R3 grant held", grant, 4'b1000);
    check("R4 cmd_valid waits for ready", cmd_valid, 1);
    check("R4 cmd_stream", cmd_stream, 3);
    run_burst(0, 0);
    exp_q.push_back(0); run_burst(1, 0);
    exp_q.push_back(1); run_burst(1, 0);
    exp_q.push_back(3); run_burst(1, 0);
    @(negedge clk);
    check("R8 all done idle", cmd_valid, 0);
    apb_read(6'h10, rd); check("R8 status", rd, 32'hB);
    apb_read(6'h00, rd); check("R8 enable cleared", rd, 0);

    // R9: write-one-to-clear
    apb_write(6'h10, 32'h1);
    apb_read(6'h10, rd); check("R9 clear bit0", rd, 32'hA);
    apb_write(6'h10, 32'h0);
    apb_read(6'h10, rd); check("R9 zero write", rd, 32'hA);
    apb_read(6'h14, rd); check("R10 unmapped", rd, 0);

    // R11: mode bit on stream 0 not stored, request still qualifies
    periph_req = 4'b0001;
    exp_q.push_back(0);
    apb_write(6'h00, 32'h3);
    apb_read(6'h00, rd); check("R11 mode reads 0", rd, 32'h1);
    run_burst(1, 0);

    // R5 / R6: stream 2 external mode
    periph_req = 4'b0100;
    xfer_addr = 16'hC000;
    apb_write(6'h08, 32'h3);
    repeat (4) step();
    @(negedge clk);
    check("R5 periph_req ignored in ext mode", cmd_valid, 0);
    exp_q.push_back(2);
    ext_req = 1;
    run_burst(0, 1);
    xfer_addr = 16'h4000;
    exp_q.push_back(2);
    run_burst(1, 0);
    ext_req = 0;
    apb_read(6'h10, rd); check("R8 status after ext", rd, 32'hF);

    // R7: stream 3 memory-to-memory start
    apb_write(6'h10, 32'hF);
    apb_read(6'h10, rd); check("R9 clear all", rd, 0);
    periph_req = 4'b0000;
    exp_q.push_back(3);
    apb_write(6'h0C, 32'h7);
    run_burst(0, 0);
    apb_read(6'h0C, rd); check("R7 start held mid-transfer", rd, 32'h7);
    exp_q.push_back(3);
    run_burst(1, 0);
    apb_read(6'h0C, rd); check("R7 start cleared", rd, 32'h2);
    apb_read(6'h10, rd); check("R8 status m2m", rd, 32'h8);

    repeat (3) step();
    @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule